// File: doc/BRIEF.md
# Frame and Multiframe Sync Generator

This block turns a free-running reference clock into two framing strobes. The frame strobe repeats at 8 kHz. The multiframe strobe repeats at 2 kHz and lines up with the start of every fourth frame. A single terminal-count divider, clocked by the reference clock, sets the frame timing. A small counter of frames sets the multiframe timing. Each output has its own shaping and polarity stage, and the output is registered so that it is free of glitches.

Two control bits set each output. One bit chooses between a 50% duty-cycle square wave and a pulse that is one reference-clock period wide. The other bit inverts the shaped waveform. The block copies the four control bits into a shadow register only at a frame boundary, so a change made part-way through a frame cannot cut that frame short. A reference-enable input acts as a count enable. While it is low, the counters hold their values, and an output in pulse mode rests at its inactive level.

Top module: `fsync_gen`

## Requirements
- R1: With pulse mode off, the frame output is a square wave with a period of DIV = REF_HZ/FRAME_HZ enabled reference cycles. It is active for the first DIV/2 cycles of each frame and inactive for the rest.
- R2: With pulse mode off, the multiframe output has a period of 4·DIV enabled cycles. It is active for the first two frames of each multiframe and inactive for the last two.
- R3: Each time the multiframe output turns active, the frame output turns active in the same cycle.
- R4: With pulse mode on, the output is active for exactly one reference cycle per period. That cycle is the first cycle of each frame for the frame output, and the first cycle of every fourth frame for the multiframe output.
- R5: With its invert bit set, an output shows the complement of its shaped waveform. This holds in both square mode and pulse mode.
- R6: The control input `cfg_i` is decoded as follows: bit 3 inverts the frame output, bit 2 turns on pulse mode for the frame output, bit 1 inverts the multiframe output, and bit 0 turns on pulse mode for the multiframe output.
- R7: A change on `cfg_i` takes effect only from the next frame boundary. The remainder of the current frame keeps the old settings.
- R8: While `ref_en` is low, both counters hold their values. An output in pulse mode then sits at its inactive level, and an output in square mode keeps its current level.
- R9: While reset is active, both outputs are low and all settings are cleared. Reset is released two reference edges after `rst_n` rises. Each output is registered and follows the counter state with a delay of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference clock enable, used as the count enable |
| cfg_i | input | 4 | Polarity and shape controls (see R6) |
| frm_sync_o | output | 1 | 8 kHz frame strobe |
| mf_sync_o | output | 1 | 2 kHz multiframe strobe |

## Verification
The bench builds the block with REF_HZ = 48000, which gives a frame of six cycles and a multiframe of twenty-four cycles. With these values, thousands of frame and multiframe boundaries occur in a short run. Random changes to the settings and random gaps in `ref_en` therefore land at every counter phase, including the wrap cycle where the shadow register loads. Because a frame is so short, a setting that is applied early is also easy to tell apart from one that waits for the boundary.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  // Field order is the decode order of cfg_i (bit 3 first).
  typedef struct packed {
    logic frm_inv;
    logic frm_pulse;
    logic mf_inv;
    logic mf_pulse;
  } fsync_cfg_t;

  localparam int unsigned NUM_OUTS = 2;
endpackage

// File: rtl/fsync_divider.sv
module fsync_divider #(
  parameter int unsigned DIV    = 2430,
  parameter int unsigned MF_LEN = 4,
  parameter int unsigned CW     = (DIV > 1) ? $clog2(DIV) : 1,
  parameter int unsigned MW     = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] cnt_o,
  output logic [MW-1:0] mf_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [MW-1:0] MF_LAST  = MW'(MF_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [MW-1:0] mf_q, mf_d;
  logic          wrap;

  always_comb begin
    wrap  = en && (cnt_q == CNT_LAST);
    cnt_d = cnt_q;
    mf_d  = mf_q;
    if (en) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        mf_d  = (mf_q == MF_LAST) ? '0 : mf_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mf_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      mf_q  <= mf_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign mf_o   = mf_q;
  assign wrap_o = wrap;

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  assert_mf_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(mf_q));
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && $stable(mf_q)));
endmodule

// File: rtl/fsync_shaper.sv
module fsync_shaper #(
  parameter int unsigned DIV    = 2430,
  parameter int unsigned MF_LEN = 4,
  parameter int unsigned CW     = (DIV > 1) ? $clog2(DIV) : 1,
  parameter int unsigned MW     = (MF_LEN > 1) ? $clog2(MF_LEN) : 1,
  parameter bit          MULTI  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt_i,
  input  logic [MW-1:0] mf_i,
  input  logic          pulse_i,
  input  logic          inv_i,
  output logic          sync_o
);
  localparam logic [CW-1:0] CNT_HALF = CW'(DIV / 2);
  localparam logic [MW-1:0] MF_HALF  = MW'(MF_LEN / 2);

  logic square, tick, shaped, out_d, out_q;

  generate
    if (MULTI) begin : g_multi
      assign square = (mf_i < MF_HALF);
      assign tick   = (mf_i == '0) && (cnt_i == '0);
    end else begin : g_frame
      assign square = (cnt_i < CNT_HALF);
      assign tick   = (cnt_i == '0);
    end
  endgenerate

  always_comb begin
    shaped = pulse_i ? (tick && en) : square;
    out_d  = shaped ^ inv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign sync_o = out_q;

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && (out_q != inv_i) && $stable(pulse_i) && $stable(inv_i))
      |=> (out_q == inv_i));
  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !en) |=> (out_q == inv_i));
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int unsigned REF_HZ   = 19_440_000,
  parameter int unsigned FRAME_HZ = 8_000,
  parameter int unsigned MF_LEN   = 4
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic [3:0] cfg_i,
  output logic       frm_sync_o,
  output logic       mf_sync_o
);
  import fsync_pkg::*;

  localparam int unsigned DIV = REF_HZ / FRAME_HZ;
  localparam int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned MW  = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [CW-1:0] cnt;
  logic [MW-1:0] mf;
  logic          wrap;
  fsync_cfg_t    shadow_q, shadow_d;

  fsync_divider #(.DIV(DIV), .MF_LEN(MF_LEN), .CW(CW), .MW(MW)) u_div (
    .clk    (clk_ref),
    .rst_n  (rst_sync_n),
    .en     (ref_en),
    .cnt_o  (cnt),
    .mf_o   (mf),
    .wrap_o (wrap)
  );

  always_comb begin
    shadow_d = wrap ? fsync_cfg_t'(cfg_i) : shadow_q;
  end

  always_ff @(posedge clk_ref or negedge rst_sync_n) begin
    if (!rst_sync_n) shadow_q <= '0;
    else             shadow_q <= shadow_d;
  end

  logic [NUM_OUTS-1:0] pulse_sel, inv_sel, sync_q;

  always_comb begin
    pulse_sel = {shadow_q.mf_pulse, shadow_q.frm_pulse};
    inv_sel   = {shadow_q.mf_inv,   shadow_q.frm_inv};
  end

  generate
    for (genvar g = 0; g < NUM_OUTS; g++) begin : g_out
      fsync_shaper #(
        .DIV(DIV), .MF_LEN(MF_LEN), .CW(CW), .MW(MW), .MULTI(g == 1)
      ) u_shape (
        .clk     (clk_ref),
        .rst_n   (rst_sync_n),
        .en      (ref_en),
        .cnt_i   (cnt),
        .mf_i    (mf),
        .pulse_i (pulse_sel[g]),
        .inv_i   (inv_sel[g]),
        .sync_o  (sync_q[g])
      );
    end
  endgenerate

  assign frm_sync_o = sync_q[0];
  assign mf_sync_o  = sync_q[1];

  assert_cfg_at_boundary_R7: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    !wrap |=> $stable(shadow_q));
  assert_reset_low_R9: assert property (@(posedge clk_ref)
    !rst_sync_n |-> (!frm_sync_o && !mf_sync_o));
endmodule

// File: tb/fsync_gen_bench.sv
module fsync_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF_HZ     = 48000;
  localparam int FRAME_HZ   = 8000;
  localparam int MF_LEN     = 4;
  localparam int DIV        = REF_HZ / FRAME_HZ;
  localparam int HALF       = DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_en;
  logic [3:0] cfg;
  logic       frm, mf;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fsync_gen #(.REF_HZ(REF_HZ), .FRAME_HZ(FRAME_HZ), .MF_LEN(MF_LEN)) u_fsync_gen (
    .clk_ref    (clk),
    .rst_n      (rst_n),
    .ref_en     (ref_en),
    .cfg_i      (cfg),
    .frm_sync_o (frm),
    .mf_sync_o  (mf)
  );

  int checks = 0;
  int errors = 0;

  // Reference model built from the requirements.
  int       m_cnt, m_mf, m_rs;
  logic [3:0] m_sh;
  logic     m_frm, m_mfo;

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic f_frame(int cnt, logic pulse, logic en);
    return pulse ? (cnt == 0 && en) : (cnt < HALF);
  endfunction

  function automatic logic f_multi(int cnt, int mfc, logic pulse, logic en);
    return pulse ? (mfc == 0 && cnt == 0 && en) : (mfc < MF_LEN / 2);
  endfunction

  task automatic model_step();
    if (!rst_n) begin
      m_rs = 0; m_cnt = 0; m_mf = 0; m_sh = '0; m_frm = 0; m_mfo = 0;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      m_frm = f_frame(m_cnt, m_sh[2], ref_en) ^ m_sh[3];
      m_mfo = f_multi(m_cnt, m_mf, m_sh[0], ref_en) ^ m_sh[1];
      if (ref_en) begin
        if (m_cnt == DIV - 1) begin
          m_cnt = 0;
          m_mf  = (m_mf + 1) % MF_LEN;
          m_sh  = cfg;
        end else begin
          m_cnt++;
        end
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(m_sh[2] ? "R4 frame pulse" : "R1 frame square", frm, m_frm);
    check(m_sh[0] ? "R4 multiframe pulse" : "R2 multiframe square", mf, m_mfo);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    int fr_rise, mf_rise, both_rise, hi, lo, guard;
    logic pf, pm, held;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; ref_en = 1'b1; cfg = 4'b0000;
    m_rs = 0; m_cnt = 0; m_mf = 0; m_sh = '0; m_frm = 0; m_mfo = 0;
    @(negedge clk);
    @(negedge clk);
    check("R9 reset frame low", frm, 1'b0);
    check("R9 reset multiframe low", mf, 1'b0);
    rst_n = 1'b1;
    cyc(); cyc();
    check("R9 held in reset two edges", frm, 1'b0);
    run(2);

    // R1/R2/R3: square mode, coincidence of active edges
    fr_rise = 0; mf_rise = 0; both_rise = 0; pf = frm; pm = mf;
    for (int i = 0; i < 4 * DIV * 3; i++) begin
      cyc();
      if (frm && !pf) fr_rise++;
      if (mf && !pm) begin
        mf_rise++;
        if (frm && !pf) both_rise++;
      end
      pf = frm; pm = mf;
    end
    check_int("R3 multiframe edges seen", (mf_rise >= 2) ? 1 : 0, 1);
    check_int("R3 multiframe edge with frame edge", both_rise, mf_rise);
    check_int("R1 frame edges per 3 multiframes", fr_rise, 12);

    // R6: only the frame pulse bit (bit 2)
    cfg = 4'b0100;
    run(2 * DIV);
    hi = 0;
    for (int i = 0; i < DIV; i++) begin cyc(); if (frm) hi++; end
    check_int("R6/R4 frame pulse width", hi, 1);
    hi = 0;
    for (int i = 0; i < 4 * DIV; i++) begin cyc(); if (mf) hi++; end
    check_int("R6 multiframe unaffected square", hi, 2 * DIV);

    // R5: both inverted, square
    cfg = 4'b1010;
    run(4 * DIV);
    lo = 0;
    for (int i = 0; i < DIV; i++) begin cyc(); if (!frm) lo++; end
    check_int("R5 frame inverted duty", lo, HALF);
    lo = 0;
    for (int i = 0; i < 4 * DIV; i++) begin cyc(); if (!mf) lo++; end
    check_int("R5 multiframe inverted duty", lo, 2 * DIV);

    // R7: change mid-frame, old settings hold to the boundary
    pf = frm; guard = 0;
    do begin pf = frm; cyc(); guard++; end while (!(pf && !frm) && guard < 4 * DIV);
    cfg = 4'b0000;
    cyc();
    check("R7 invert kept until boundary", frm, 1'b0);
    run(2 * DIV);

    // R8: pulse mode with reference disabled
    cfg = 4'b0101;
    run(5 * DIV);
    ref_en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      cyc();
      check("R8 frame pulse idle", frm, 1'b0);
      check("R8 multiframe pulse idle", mf, 1'b0);
    end
    ref_en = 1'b1;
    cfg = 4'b0000;
    run(4 * DIV + 2);
    ref_en = 1'b0;
    cyc();
    held = frm;
    for (int i = 0; i < 5; i++) begin cyc(); check("R8 square level held", frm, held); end
    ref_en = 1'b1;

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 25 == 0) cfg = 4'($urandom);
      ref_en = ($urandom % 10) != 0;
      cyc();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule